// File: doc/BRIEF.md
# Multi-Channel I/Q Output Port

This block collects complex baseband samples from six gain-controlled receive channels and sends them out over one shared 16-bit word bus. Each channel delivers a sample through a one-cycle valid strobe that carries an I word, a Q word and a gain word. The sample waits in a one-entry holding slot for that channel until the port takes it. Pending channels are served one frame at a time, lowest channel number first.

A frame is either an I word followed by a Q word, or a single packed word that holds both halves. A gain word may be appended to either form. Side-band outputs travel with every word: the channel number, an I/Q marker and a gain marker. The far side either acknowledges each word, which is slave operation, or takes one word on every clock while the request is high, which is master operation. All inputs are assumed to be in the port clock domain.

Top module: `mc_iq_out_port`

## Requirements
- R1: After reset, portReq is low, portData, portChan, portIq and portGain are 0, and overflow is all zeros.
- R2: With masterMode=0, a word is transferred only on a rising edge where portReq and portAck are both high. While portAck is low, portData, portChan, portIq and portGain hold their values.
- R3: With masterMode=1, one word is transferred on every rising edge while portReq is high, whatever the value of portAck.
- R4: With fmtParallel=0, a frame first carries the I word with portIq=1, then the Q word with portIq=0.
- R5: With fmtParallel=1, a frame carries one word {I[15:8], Q[15:8]} with portIq=1.
- R6: With appendGain=1, the frame ends with one extra word holding the gain word, with portGain=1 and portIq=0. portGain is 0 on every other word.
- R7: portChan equals the number of the channel whose frame is on the bus, for every word of that frame.
- R8: When several channels are pending, their frames are sent in ascending channel order.
- R9: A sample strobe on a channel whose chEn bit is 0 is ignored and produces no frame.
- R10: A new sample that arrives while an older unsent sample is still pending replaces the older one. It also sets the sticky overflow bit for that channel, and the bit stays set until reset.
- R11: A sample that arrives on the same edge as that channel's held sample is taken into a frame stays pending for a later frame and does not set overflow.
- R12: When the last word of a frame transfers and another channel is pending, the first word of the next frame is on the bus in the very next cycle, so portReq does not drop between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = master operation, 0 = slave (acknowledged) operation |
| fmtParallel | input | 1 | 1 = packed I/Q word, 0 = I then Q; sampled when a frame starts |
| appendGain | input | 1 | 1 = append gain word to each frame; sampled when a frame starts |
| chEn | input | 6 | Per-channel enable |
| sampValid | input | 6 | Per-channel one-cycle sample strobe |
| sampI | input | 96 | I words, channel c at bits [16c+15:16c] |
| sampQ | input | 96 | Q words, same packing as sampI |
| sampGain | input | 96 | Gain words, same packing as sampI |
| portAck | input | 1 | Word acknowledge from the receiver (slave operation) |
| portReq | output | 1 | A word is on the bus |
| portData | output | 16 | Word bus |
| portChan | output | 3 | Channel number of the current word |
| portIq | output | 1 | High for an I word or a packed word |
| portGain | output | 1 | High for a gain word |
| overflow | output | 6 | Sticky per-channel overwrite flags |

## Verification
Two things can happen to one channel on the same clock edge: its held sample is moved into the outgoing frame, and a fresh strobe arrives for that channel. The bench provokes this by strobing channel 2 on two consecutive cycles while the port is idle. The second strobe then meets the frame load. The run is judged correct when both samples come out as separate frames in arrival order and the channel's overflow bit stays clear. The other case, a strobe that lands on a slot which is still pending, is provoked by stalling acknowledge. That case must set the flag and deliver only the newer sample.

// File: rtl/mcop_pkg.sv
package mcop_pkg;
  localparam int NUM_CH = 6;
  localparam int DATA_W = 16;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    WK_I    = 2'd0,
    WK_Q    = 2'd1,
    WK_PAIR = 2'd2,
    WK_GAIN = 2'd3
  } word_kind_e;

  typedef struct packed {
    logic              load;
    logic [CH_W-1:0]   loadCh;
    logic              active;
    word_kind_e        kind;
  } port_ctrl_s;
endpackage

// File: rtl/mcop_ctrl.sv
module mcop_ctrl
  import mcop_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           masterMode,
  input  logic           fmtParallel,
  input  logic           appendGain,
  input  logic           ack,
  input  logic [NCH-1:0] pending,
  output port_ctrl_s     ctrl,
  output logic           req
);
  logic          active;
  logic [1:0]    wordIdx;
  logic          fmtLat;
  logic          appLat;
  logic [1:0]    lastIdx;
  logic          isLast;
  logic          xfer;
  logic          anyPend;
  logic [CW-1:0] pickCh;
  logic          load;
  word_kind_e    kind;

  // lowest pending channel wins
  always_comb begin
    pickCh = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pending[c]) pickCh = CW'(c);
    end
  end

  assign anyPend = |pending;
  assign lastIdx = fmtLat ? (appLat ? 2'd1 : 2'd0) : (appLat ? 2'd2 : 2'd1);
  assign isLast  = (wordIdx == lastIdx);
  assign xfer    = active && (masterMode || ack);
  assign load    = anyPend && (!active || (xfer && isLast));

  always_comb begin
    if (fmtLat) begin
      kind = (wordIdx == 2'd0) ? WK_PAIR : WK_GAIN;
    end else begin
      case (wordIdx)
        2'd0:    kind = WK_I;
        2'd1:    kind = WK_Q;
        default: kind = WK_GAIN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wordIdx <= 2'd0;
      fmtLat  <= 1'b0;
      appLat  <= 1'b0;
    end else if (load) begin
      active  <= 1'b1;
      wordIdx <= 2'd0;
      fmtLat  <= fmtParallel;
      appLat  <= appendGain;
    end else if (xfer) begin
      if (isLast) begin
        active  <= 1'b0;
        wordIdx <= 2'd0;
      end else begin
        wordIdx <= wordIdx + 2'd1;
      end
    end
  end

  assign ctrl.load   = load;
  assign ctrl.loadCh = pickCh;
  assign ctrl.active = active;
  assign ctrl.kind   = kind;
  assign req         = active;

  // R2
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !masterMode && !ack) |=> (active && $stable(wordIdx)));

  // R3
  master_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && masterMode && !isLast) |=> (active && wordIdx == $past(wordIdx) + 2'd1));

  // R12
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && isLast && anyPend) |=> (active && wordIdx == 2'd0));
endmodule

// File: rtl/mcop_datapath.sv
module mcop_datapath
  import mcop_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int CW  = CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chEn,
  input  logic [NCH-1:0]    sampValid,
  input  logic [NCH*DW-1:0] sampI,
  input  logic [NCH*DW-1:0] sampQ,
  input  logic [NCH*DW-1:0] sampGain,
  input  port_ctrl_s        ctrl,
  output logic [NCH-1:0]    pending,
  output logic [NCH-1:0]    ovf,
  output logic [DW-1:0]     busData,
  output logic [CW-1:0]     chanId,
  output logic              iqFlag,
  output logic              gainFlag
);
  localparam int HW = DW / 2;

  logic [DW-1:0] bufI [NCH];
  logic [DW-1:0] bufQ [NCH];
  logic [DW-1:0] bufG [NCH];
  logic [NCH-1:0] take;
  logic [NCH-1:0] capture;
  logic [DW-1:0] frI, frQ, frG;
  logic [CW-1:0] frCh;

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign take[c]    = ctrl.load && (ctrl.loadCh == CW'(c));
    assign capture[c] = sampValid[c] && chEn[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[c] <= 1'b0;
        ovf[c]     <= 1'b0;
        bufI[c]    <= '0;
        bufQ[c]    <= '0;
        bufG[c]    <= '0;
      end else begin
        if (capture[c]) begin
          bufI[c]    <= sampI[c*DW +: DW];
          bufQ[c]    <= sampQ[c*DW +: DW];
          bufG[c]    <= sampGain[c*DW +: DW];
          pending[c] <= 1'b1;
          if (pending[c] && !take[c]) ovf[c] <= 1'b1;
        end else if (take[c]) begin
          pending[c] <= 1'b0;
        end
      end
    end

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[c] |=> ovf[c]);

    // R11
    same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture[c] && take[c] && !ovf[c]) |=> (pending[c] && !ovf[c]));

    // R9
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chEn[c] && !pending[c]) |=> !pending[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frI  <= '0;
      frQ  <= '0;
      frG  <= '0;
      frCh <= '0;
    end else if (ctrl.load) begin
      frI  <= bufI[ctrl.loadCh];
      frQ  <= bufQ[ctrl.loadCh];
      frG  <= bufG[ctrl.loadCh];
      frCh <= ctrl.loadCh;
    end
  end

  always_comb begin
    busData  = '0;
    chanId   = '0;
    iqFlag   = 1'b0;
    gainFlag = 1'b0;
    if (ctrl.active) begin
      chanId = frCh;
      case (ctrl.kind)
        WK_I:    begin busData = frI; iqFlag = 1'b1; end
        WK_Q:    busData = frQ;
        WK_PAIR: begin busData = {frI[DW-1 -: HW], frQ[DW-1 -: HW]}; iqFlag = 1'b1; end
        default: begin busData = frG; gainFlag = 1'b1; end
      endcase
    end
  end

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iqFlag && gainFlag));
endmodule

// File: rtl/mc_iq_out_port.sv
module mc_iq_out_port
  import mcop_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int CW  = CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              fmtParallel,
  input  logic              appendGain,
  input  logic [NCH-1:0]    chEn,
  input  logic [NCH-1:0]    sampValid,
  input  logic [NCH*DW-1:0] sampI,
  input  logic [NCH*DW-1:0] sampQ,
  input  logic [NCH*DW-1:0] sampGain,
  input  logic              portAck,
  output logic              portReq,
  output logic [DW-1:0]     portData,
  output logic [CW-1:0]     portChan,
  output logic              portIq,
  output logic              portGain,
  output logic [NCH-1:0]    overflow
);
  port_ctrl_s     ctrl;
  logic [NCH-1:0] pending;

  mcop_ctrl #(.NCH(NCH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode), .fmtParallel(fmtParallel),
    .appendGain(appendGain), .ack(portAck), .pending(pending & chEn),
    .ctrl(ctrl), .req(portReq)
  );

  mcop_datapath #(.NCH(NCH), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .chEn(chEn), .sampValid(sampValid),
    .sampI(sampI), .sampQ(sampQ), .sampGain(sampGain), .ctrl(ctrl),
    .pending(pending), .ovf(overflow), .busData(portData), .chanId(portChan),
    .iqFlag(portIq), .gainFlag(portGain)
  );
endmodule

// File: tb/mc_iq_out_port_tb.sv
module mc_iq_out_port_tb;
  localparam int NCH = 6;
  localparam int DW  = 16;

  typedef struct packed {
    logic [15:0] data;
    logic [2:0]  ch;
    logic        iq;
    logic        gain;
  } word_t;

  logic clk = 0;
  logic rst_n = 0;
  logic masterMode = 0, fmtParallel = 0, appendGain = 0;
  logic [NCH-1:0] chEn = '1;
  logic [NCH-1:0] sampValid = '0;
  logic [NCH*DW-1:0] sampI = '0, sampQ = '0, sampGain = '0;
  logic portAck = 0;
  logic portReq;
  logic [15:0] portData;
  logic [2:0] portChan;
  logic portIq, portGain;
  logic [NCH-1:0] overflow;

  int checks = 0, failures = 0;
  int reqCycles = 0;
  int ackMode = 0;
  logic [3:0] ackCnt = '0;
  bit started = 0;
  word_t expQ[$];
  string tagQ[$];
  bit prevStall = 0;
  word_t prevW;

  always #2 clk = ~clk;

  mc_iq_out_port u_dut (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode), .fmtParallel(fmtParallel),
    .appendGain(appendGain), .chEn(chEn), .sampValid(sampValid), .sampI(sampI),
    .sampQ(sampQ), .sampGain(sampGain), .portAck(portAck), .portReq(portReq),
    .portData(portData), .portChan(portChan), .portIq(portIq), .portGain(portGain),
    .overflow(overflow)
  );

  function automatic logic [15:0] mkI(int ch, int s); return 16'hA000 | 16'(ch << 8) | 16'(s); endfunction
  function automatic logic [15:0] mkQ(int ch, int s); return 16'h5000 | 16'(ch << 8) | 16'(s + 3); endfunction
  function automatic logic [15:0] mkG(int ch, int s); return 16'h0C00 | 16'(ch << 4) | 16'(s); endfunction

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic pushW(logic [15:0] d, int ch, bit iq, bit g, string tag);
    word_t w;
    w.data = d; w.ch = 3'(ch); w.iq = iq; w.gain = g;
    expQ.push_back(w);
    tagQ.push_back(tag);
  endtask

  // driver: expected words of one frame per the requirements
  task automatic pushFrame(int ch, int s, bit fmt, bit app, string tag);
    logic [15:0] i, q;
    i = mkI(ch, s); q = mkQ(ch, s);
    if (fmt) pushW({i[15:8], q[15:8]}, ch, 1'b1, 1'b0, {tag, "/R5/R7"});
    else begin
      pushW(i, ch, 1'b1, 1'b0, {tag, "/R4/R7"});
      pushW(q, ch, 1'b0, 1'b0, {tag, "/R4/R7"});
    end
    if (app) pushW(mkG(ch, s), ch, 1'b0, 1'b1, {tag, "/R6"});
  endtask

  task automatic setSamples(logic [NCH-1:0] mask, int s);
    sampValid = mask;
    for (int c = 0; c < NCH; c++) begin
      sampI[c*DW +: DW]    = mkI(c, s);
      sampQ[c*DW +: DW]    = mkQ(c, s);
      sampGain[c*DW +: DW] = mkG(c, s);
    end
  endtask

  task automatic inject(logic [NCH-1:0] mask, int s);
    @(posedge clk); #1;
    setSamples(mask, s);
    @(posedge clk); #1;
    sampValid = '0;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((expQ.size() != 0 || portReq) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !portReq, tag,
          $sformatf("leftover words actual=%0d expected=0", expQ.size()));
    expQ.delete(); tagQ.delete();
  endtask

  // acknowledge driver
  always @(posedge clk) begin
    #1;
    ackCnt <= ackCnt + 4'd1;
    case (ackMode)
      0: portAck <= 1'b0;
      1: portAck <= 1'b1;
      default: portAck <= ackCnt[0] ^ ackCnt[2];
    endcase
  end

  // monitor: compare transferred words against the scoreboard
  always @(negedge clk) begin
    if (started) begin
      word_t cur;
      cur.data = portData; cur.ch = portChan; cur.iq = portIq; cur.gain = portGain;
      if (portReq) reqCycles++;
      if (prevStall)
        check(cur == prevW, "R2", $sformatf("held word actual=%h expected=%h", cur, prevW));
      prevStall = portReq && !masterMode && !portAck;
      prevW = cur;
      if (portReq && (masterMode || portAck)) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", $sformatf("unexpected word actual=%h expected=none", cur));
        end else begin
          word_t e;
          string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(cur == e, t, $sformatf("word actual=%h expected=%h", cur, e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    check(!portReq && portData == 0 && portChan == 0 && !portIq && !portGain && overflow == 0,
          "R1", $sformatf("reset outputs actual=%b/%h/%0d/%b/%b/%b expected=0",
                          portReq, portData, portChan, portIq, portGain, overflow));
    started = 1;

    // R4 slave, irregular ack
    ackMode = 2; fmtParallel = 0; appendGain = 0;
    pushFrame(0, 1, 0, 0, "R2");
    inject(6'b000001, 1);
    drain("R4");

    // R5 + R6 packed with gain, ascending order
    ackMode = 1; fmtParallel = 1; appendGain = 1;
    pushFrame(2, 2, 1, 1, "R8");
    pushFrame(4, 2, 1, 1, "R8");
    inject(6'b010100, 2);
    drain("R5");

    // R6 interleaved with gain
    fmtParallel = 0; appendGain = 1; ackMode = 2;
    pushFrame(5, 3, 0, 1, "R6");
    inject(6'b100000, 3);
    drain("R6");

    // R8 ascending order
    appendGain = 0;
    pushFrame(1, 4, 0, 0, "R8");
    pushFrame(3, 4, 0, 0, "R8");
    pushFrame(5, 4, 0, 0, "R8");
    inject(6'b101010, 4);
    drain("R8");

    // R9 disabled channel
    chEn = 6'b110111;
    pushFrame(4, 5, 0, 0, "R9");
    inject(6'b011000, 5);
    drain("R9");
    chEn = '1;

    // R3 + R12 master, no ack, back-to-back frames
    masterMode = 1; ackMode = 0;
    rc = reqCycles;
    pushFrame(0, 6, 0, 0, "R3");
    pushFrame(1, 6, 0, 0, "R3");
    pushFrame(2, 6, 0, 0, "R3");
    inject(6'b000111, 6);
    drain("R3");
    check(reqCycles - rc == 6, "R12",
          $sformatf("req cycles actual=%0d expected=6", reqCycles - rc));
    masterMode = 0;

    // R10 overwrite under stall
    ackMode = 0;
    pushFrame(0, 7, 0, 0, "R10");
    pushFrame(1, 9, 0, 0, "R10");
    inject(6'b000001, 7);
    inject(6'b000010, 8);
    inject(6'b000010, 9);
    @(negedge clk);
    check(overflow == 6'b000010 && portReq, "R10",
          $sformatf("overflow actual=%b expected=000010", overflow));
    ackMode = 1;
    drain("R10");
    check(overflow == 6'b000010, "R10",
          $sformatf("sticky overflow actual=%b expected=000010", overflow));

    // R11 strobe on the same edge as the frame load
    pushFrame(2, 10, 0, 0, "R11");
    pushFrame(2, 11, 0, 0, "R11");
    @(posedge clk); #1;
    setSamples(6'b000100, 10);
    @(posedge clk); #1;
    setSamples(6'b000100, 11);
    @(posedge clk); #1;
    sampValid = '0;
    drain("R11");
    check(overflow[2] == 1'b0, "R11",
          $sformatf("overflow[2] actual=%b expected=0", overflow[2]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule